// File: doc/BRIEF.md
# Multiplexed Host Port Cycle Sequencer

This block runs exactly one bus cycle on a target's multiplexed host port for each start request it accepts. The bus has sixteen shared address/data lines plus one extra top address line. A cycle is either an address cycle, which pulses the latch pin, or a data cycle, which pulses the active-low read or write strobe. Memory or I/O space is chosen by one of two active-low chip selects. The sequencer enables its bus drivers during writes and address cycles. It holds the strobe until the target raises its active-high acknowledge, observes a minimum setup and hold around the strobe, and then gives a one-cycle done pulse. For reads it also returns the captured word.

A complete target access is made from several runs. A direct access is an address run followed by one or more data runs. A block transfer uses data runs only. A 24-bit word over the 16-bit bus takes one address run and two data runs. During reset, and for a fixed number of clocks after it, the block holds the shared control pins at the levels the target samples to pick its modes. In this window the latch pin is high, both strobes are high, and `cfgDrive` is high. That output tells the board to pull the acknowledge pin low and the acknowledge-polarity pin high. An abort input from an external watchdog ends any cycle at once.

Top module: `mux_host_cycle_seq`

## Requirements
- R1: While `rstN` is low, and until `CFG_CYCLES` rising clock edges have passed after its release, `cfgDrive`, `latchPin`, `rdStrobeN` and `wrStrobeN` are all 1 and both selects are 1. A `startReq` seen in this window is dropped.
- R2: An address run (`cycAddr`=1) raises only `latchPin`, drives `busOut`=`wordIn[15:0]` with `busOe`=1, and drives `topAddr`=`wordIn[16]`.
- R3: A data write (`cycAddr`=0, `cycWrite`=1) pulls only `wrStrobeN` low, drives `busOut`=`wordIn[15:0]` with `busOe`=1, and holds `topAddr` at 0.
- R4: A data read (`cycAddr`=0, `cycWrite`=0) pulls only `rdStrobeN` low and keeps `busOe` at 0 for the whole run. `rdData` becomes the `busIn` value present on the clock edge where the strobe is released, and it is valid by the time `done` rises.
- R5: `selMem`=1 selects `memSelN` and `selMem`=0 selects `ioSelN`. At most one select is low at a time, and both are high when the block is idle and while `done` is high.
- R6: The select goes low exactly `SETUP_CYC` clocks before the strobe becomes active.
- R7: The strobe stays active until `ackIn` is sampled high, for at least two clocks. The select stays low exactly `HOLD_CYC` clocks after the strobe is released.
- R8: `done` is high for exactly one clock, in the clock after the select goes high. Cycle parameters are latched when a start is accepted. A `startReq` raised while a run is in progress is ignored.
- R9: In the clock after `abort` is sampled high, all strobes are inactive, both selects are high and `busOe` is 0. No `done` follows the abort, and the block accepts a new start afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one bus cycle (taken when idle is high) |
| cycAddr | input | 1 | 1 = address cycle, 0 = data cycle |
| cycWrite | input | 1 | Data cycle direction: 1 = write, 0 = read |
| selMem | input | 1 | 1 = memory select, 0 = I/O select |
| wordIn | input | 17 | Shifted address (bit 16 = top line) or write data |
| abort | input | 1 | Watchdog abort |
| ackIn | input | 1 | Target acknowledge, active high |
| busIn | input | 16 | Multiplexed bus as seen at the pins |
| busOut | output | 16 | Value driven onto the multiplexed bus |
| busOe | output | 1 | Bus driver enable |
| topAddr | output | 1 | Extra top address line |
| latchPin | output | 1 | Address-cycle strobe and reset-time mode level |
| rdStrobeN | output | 1 | Read strobe, active low |
| wrStrobeN | output | 1 | Write strobe, active low |
| memSelN | output | 1 | Memory space select, active low |
| ioSelN | output | 1 | I/O space select, active low |
| cfgDrive | output | 1 | Mode-configuration window: drive ack pin low, ack-polarity pin high |
| done | output | 1 | One-clock completion pulse |
| idle | output | 1 | Ready to accept a start |
| rdData | output | 16 | Word captured by the last read |

## Verification
Two situations are hard to reach from the ports. The first is a start arriving while a run is in flight. The second is an abort landing while the strobe waits for an acknowledge that has not yet come. The bench controls the acknowledge latency of its target model. It sets long latencies so that the block is parked in the wait phase, then raises a stray start carrying different parameters, or an abort, at a known clock. It then checks that no second cycle appears, that no done pulse follows, and that the pins go quiet in the next clock. Random runs vary the latency from zero upward, so that the rule of at least two strobe clocks and the exact setup and hold counts are checked at both ends.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_HOLD,
    ST_DONE
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;      // latch cycle parameters
    logic capture;   // register read data
    logic selOn;     // chip select active
    logic driveBus;  // enable bus drivers
    logic latchOn;   // address strobe
    logic rdOn;      // read strobe
    logic wrOn;      // write strobe
  } ctlStrobe_t;

endpackage

// File: rtl/hcs_ctrl.sv
module hcs_ctrl
  import hcs_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int CFG_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       abort,
  input  logic       ackIn,
  input  logic       isAddr,
  input  logic       isWrite,
  output ctlStrobe_t ctl,
  output logic       cfgPhase,
  output logic       done,
  output logic       idle
);

  localparam int MAXC = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int CFGW = $clog2(CFG_CYCLES + 1);
  localparam logic [CW-1:0]   SETUP_LIM = CW'(SETUP_CYC);
  localparam logic [CW-1:0]   HOLD_LIM  = CW'(HOLD_CYC);
  localparam logic [CFGW-1:0] CFG_INIT  = CFGW'(CFG_CYCLES);

  seqState_e       state;
  logic [CW-1:0]   cnt;
  logic [CFGW-1:0] cfgCnt;
  logic            strobeOn;
  logic            rdCycle;

  assign cfgPhase = (cfgCnt != '0);
  assign strobeOn = (state == ST_STROBE) || (state == ST_WAIT);
  assign rdCycle  = !isAddr && !isWrite;

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == ST_IDLE) && startReq && !cfgPhase && !abort;
    ctl.selOn    = (state == ST_SETUP) || strobeOn || (state == ST_HOLD);
    ctl.driveBus = ctl.selOn && !rdCycle;
    ctl.latchOn  = strobeOn && isAddr;
    ctl.wrOn     = strobeOn && !isAddr && isWrite;
    ctl.rdOn     = strobeOn && rdCycle;
    ctl.capture  = (state == ST_WAIT) && ackIn && !abort && rdCycle;
  end

  assign done = (state == ST_DONE) && !abort;
  assign idle = (state == ST_IDLE) && !cfgPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cfgCnt <= CFG_INIT;
    end else begin
      if (cfgPhase) cfgCnt <= cfgCnt - 1'b1;
      if (abort) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (ctl.load) begin
            state <= ST_SETUP;
            cnt   <= CW'(1);
          end
          ST_SETUP: if (cnt >= SETUP_LIM) state <= ST_STROBE;
                    else cnt <= cnt + 1'b1;
          ST_STROBE: state <= ST_WAIT;
          ST_WAIT: if (ackIn) begin
            state <= ST_HOLD;
            cnt   <= CW'(1);
          end
          ST_HOLD: if (cnt >= HOLD_LIM) state <= ST_DONE;
                   else cnt <= cnt + 1'b1;
          ST_DONE: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/hcs_path.sv
module hcs_path
  import hcs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              cfgPhase,
  input  logic              cycAddr,
  input  logic              cycWrite,
  input  logic              selMem,
  input  logic [DATA_W:0]   wordIn,
  input  logic [DATA_W-1:0] busIn,
  output logic              isAddr,
  output logic              isWrite,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              topAddr,
  output logic              latchPin,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic              memSelN,
  output logic              ioSelN,
  output logic [DATA_W-1:0] rdData
);

  logic            memQ;
  logic [DATA_W:0] wordQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isAddr  <= 1'b0;
      isWrite <= 1'b0;
      memQ    <= 1'b0;
      wordQ   <= '0;
      rdData  <= '0;
    end else begin
      if (ctl.load) begin
        isAddr  <= cycAddr;
        isWrite <= cycWrite;
        memQ    <= selMem;
        wordQ   <= wordIn;
      end
      if (ctl.capture) rdData <= busIn;
    end
  end

  assign busOe     = ctl.driveBus;
  assign busOut    = ctl.driveBus ? wordQ[DATA_W-1:0] : '0;
  assign topAddr   = ctl.driveBus && isAddr && wordQ[DATA_W];
  assign latchPin  = ctl.latchOn || cfgPhase;
  assign rdStrobeN = !ctl.rdOn;
  assign wrStrobeN = !ctl.wrOn;
  assign memSelN   = !(ctl.selOn && memQ);
  assign ioSelN    = !(ctl.selOn && !memQ);

endmodule

// File: rtl/mux_host_cycle_seq.sv
module mux_host_cycle_seq
  import hcs_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int CFG_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              cycAddr,
  input  logic              cycWrite,
  input  logic              selMem,
  input  logic [DATA_W:0]   wordIn,
  input  logic              abort,
  input  logic              ackIn,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              topAddr,
  output logic              latchPin,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic              memSelN,
  output logic              ioSelN,
  output logic              cfgDrive,
  output logic              done,
  output logic              idle,
  output logic [DATA_W-1:0] rdData
);

  ctlStrobe_t ctl;
  logic       cfgPhase;
  logic       isAddr;
  logic       isWrite;

  assign cfgDrive = cfgPhase;

  hcs_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .CFG_CYCLES(CFG_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .abort    (abort),
    .ackIn    (ackIn),
    .isAddr   (isAddr),
    .isWrite  (isWrite),
    .ctl      (ctl),
    .cfgPhase (cfgPhase),
    .done     (done),
    .idle     (idle)
  );

  hcs_path #(
    .DATA_W(DATA_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cfgPhase  (cfgPhase),
    .cycAddr   (cycAddr),
    .cycWrite  (cycWrite),
    .selMem    (selMem),
    .wordIn    (wordIn),
    .busIn     (busIn),
    .isAddr    (isAddr),
    .isWrite   (isWrite),
    .busOut    (busOut),
    .busOe     (busOe),
    .topAddr   (topAddr),
    .latchPin  (latchPin),
    .rdStrobeN (rdStrobeN),
    .wrStrobeN (wrStrobeN),
    .memSelN   (memSelN),
    .ioSelN    (ioSelN),
    .rdData    (rdData)
  );

endmodule

// File: rtl/mux_host_cycle_seq_chk.sv
module mux_host_cycle_seq_chk (
  input logic clk,
  input logic rstN,
  input logic abort,
  input logic ackIn,
  input logic latchPin,
  input logic rdStrobeN,
  input logic wrStrobeN,
  input logic memSelN,
  input logic ioSelN,
  input logic busOe,
  input logic done,
  input logic cfgDrive
);

  // R1
  cfg_levels_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgDrive |-> (latchPin && rdStrobeN && wrStrobeN && memSelN && ioSelN));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({latchPin && !cfgDrive, !rdStrobeN, !wrStrobeN}) <= 1);

  // R4
  rd_nodrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobeN |-> !busOe);

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!memSelN, !ioSelN}));

  // R5
  done_nosel_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (memSelN && ioSelN));

  // R7
  wr_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStrobeN && !ackIn && !abort) |=> !wrStrobeN);

  // R7
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobeN && !ackIn && !abort) |=> !rdStrobeN);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (rdStrobeN && wrStrobeN && memSelN && ioSelN && !busOe && !done
               && (!latchPin || cfgDrive)));

endmodule

bind mux_host_cycle_seq mux_host_cycle_seq_chk u_chk (.*);

// File: tb/mux_host_cycle_seq_bench.sv
`timescale 1ns/1ps
module mux_host_cycle_seq_bench;

  localparam int SETUP_CYC  = 2;
  localparam int HOLD_CYC   = 1;
  localparam int CFG_CYCLES = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, cycAddr = 1'b0, cycWrite = 1'b0, selMem = 1'b0;
  logic [16:0] wordIn = '0;
  logic        abort = 1'b0, ackIn = 1'b0;
  logic [15:0] busIn = 16'h5A5A;
  logic [15:0] busOut, rdData;
  logic        busOe, topAddr, latchPin, rdStrobeN, wrStrobeN, memSelN, ioSelN;
  logic        cfgDrive, done, idle;

  always #2.5 clk = ~clk;

  mux_host_cycle_seq #(
    .DATA_W(16), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .CFG_CYCLES(CFG_CYCLES)
  ) u_mux_host_cycle_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cycAddr(cycAddr), .cycWrite(cycWrite),
    .selMem(selMem), .wordIn(wordIn), .abort(abort), .ackIn(ackIn), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .topAddr(topAddr), .latchPin(latchPin),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .memSelN(memSelN), .ioSelN(ioSelN),
    .cfgDrive(cfgDrive), .done(done), .idle(idle), .rdData(rdData)
  );

  int total = 0, bad = 0;
  int setupCnt, holdCnt, latchCnt, rdCnt, wrCnt, doneCnt, cfgHigh, waitCnt, ackDelay;
  bit memSeen, ioSeen, bothSel, strobeSeen, oeOnRead, curRead, selDuringCfg;
  logic [15:0] busSeen, tgtData;
  logic        topSeen;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearStats();
    setupCnt = 0; holdCnt = 0; latchCnt = 0; rdCnt = 0; wrCnt = 0; doneCnt = 0;
    memSeen = 0; ioSeen = 0; bothSel = 0; strobeSeen = 0; oeOnRead = 0;
    busSeen = '0; topSeen = 1'b0;
  endtask

  // strobe length for a target that answers after d strobe clocks
  function automatic int expStrobe(input int d);
    return (d < 1) ? 2 : d + 1;
  endfunction

  // monitor and target model, sampled away from the active edge
  always @(negedge clk) begin
    bit sel, stb;
    sel = !memSelN || !ioSelN;
    stb = !cfgDrive && (latchPin || !rdStrobeN || !wrStrobeN);
    if (cfgDrive) begin
      cfgHigh++;
      if (sel) selDuringCfg = 1;
    end
    if (done) doneCnt++;
    if (!memSelN) memSeen = 1;
    if (!ioSelN) ioSeen = 1;
    if (!memSelN && !ioSelN) bothSel = 1;
    if (sel && !stb && !strobeSeen) setupCnt++;
    if (sel && !stb && strobeSeen) holdCnt++;
    if (curRead && busOe) oeOnRead = 1;
    if (stb) begin
      strobeSeen = 1;
      if (latchPin) latchCnt++;
      if (!rdStrobeN) rdCnt++;
      if (!wrStrobeN) wrCnt++;
      busSeen = busOut;
      topSeen = topAddr;
      if (waitCnt >= ackDelay) begin
        ackIn = 1'b1;
        busIn = tgtData;
      end
      waitCnt++;
    end else begin
      ackIn = 1'b0;
      waitCnt = 0;
      busIn = 16'h5A5A;
    end
  end

  task automatic runCycle(input bit a, input bit w, input bit m, input logic [16:0] word,
                          input int d, input logic [15:0] rv, input bit junk);
    int expS;
    @(negedge clk); #1;
    clearStats();
    cycAddr = a; cycWrite = w; selMem = m; wordIn = word;
    ackDelay = d; tgtData = rv; curRead = !a && !w;
    startReq = 1'b1;
    @(negedge clk); #1;
    startReq = 1'b0;
    wordIn = word ^ 17'h1FFFF; selMem = !m;
    if (junk) begin
      repeat (2) @(negedge clk);
      #1;
      cycAddr = 1'b1; wordIn = 17'h1_2345; startReq = 1'b1;
      @(negedge clk); #1;
      startReq = 1'b0;
    end
    for (int i = 0; i < 400 && doneCnt == 0; i++) begin
      @(negedge clk); #1;
    end
    repeat (4) @(negedge clk);
    #1;
    curRead = 1'b0;
    expS = expStrobe(d);
    // R8: exactly one done, nothing launched afterwards
    chk(doneCnt == 1, "R8 done count", doneCnt, 1);
    chk(idle == 1'b1, "R8 idle after run", idle, 1);
    // R6 / R7: setup and hold spans
    chk(setupCnt == SETUP_CYC, "R6 setup clocks", setupCnt, SETUP_CYC);
    chk(holdCnt == HOLD_CYC, "R7 hold clocks", holdCnt, HOLD_CYC);
    if (a) begin
      chk(latchCnt == expS && rdCnt == 0 && wrCnt == 0, "R2 latch clocks", latchCnt, expS);
      chk(busSeen == word[15:0], "R2 address bus", busSeen, word[15:0]);
      chk(topSeen == word[16], "R2 top line", topSeen, word[16]);
    end else if (w) begin
      chk(wrCnt == expS && rdCnt == 0 && latchCnt == 0, "R3 write clocks", wrCnt, expS);
      chk(busSeen == word[15:0], "R3 write bus", busSeen, word[15:0]);
      chk(topSeen == 1'b0, "R3 top line", topSeen, 0);
    end else begin
      chk(rdCnt == expS && wrCnt == 0 && latchCnt == 0, "R4 read clocks", rdCnt, expS);
      chk(rdData == rv, "R4 read data", rdData, rv);
      chk(!oeOnRead, "R4 bus released", oeOnRead, 0);
    end
    chk(memSeen == m && ioSeen == !m && !bothSel, "R5 select choice",
        {memSeen, ioSeen, bothSel}, {m, !m, 1'b0});
  endtask

  task automatic abortRun(input bit w);
    @(negedge clk); #1;
    clearStats();
    cycAddr = 1'b0; cycWrite = w; selMem = 1'b1; wordIn = 17'h0_BEEF;
    ackDelay = 40; tgtData = 16'h1111; curRead = !w;
    startReq = 1'b1;
    @(negedge clk); #1;
    startReq = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    abort = 1'b1;
    @(negedge clk); #1;
    abort = 1'b0;
    chk(rdStrobeN && wrStrobeN && memSelN && ioSelN && !busOe && !latchPin,
        "R9 pins quiet after abort",
        {rdStrobeN, wrStrobeN, memSelN, ioSelN, busOe, latchPin}, 6'b111100);
    repeat (6) @(negedge clk);
    #1;
    chk(doneCnt == 0, "R9 no done after abort", doneCnt, 0);
    chk(idle == 1'b1, "R9 idle after abort", idle, 1);
    curRead = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ackDelay = 0; tgtData = '0; waitCnt = 0; cfgHigh = 0; selDuringCfg = 0; curRead = 0;
    clearStats();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset levels
    chk(cfgDrive && latchPin && rdStrobeN && wrStrobeN && memSelN && ioSelN,
        "R1 reset levels", {cfgDrive, latchPin, rdStrobeN, wrStrobeN, memSelN, ioSelN}, 6'h3F);
    rstN = 1'b1;
    cfgHigh = 0;
    selMem = 1'b1; cycAddr = 1'b1; startReq = 1'b1;
    for (int i = 0; i < 30 && cfgDrive; i++) begin
      @(negedge clk); #1;
    end
    startReq = 1'b0;
    chk(cfgHigh == CFG_CYCLES - 1, "R1 window length", cfgHigh, CFG_CYCLES - 1);
    chk(!selDuringCfg, "R1 no select in window", selDuringCfg, 0);
    repeat (4) @(negedge clk);
    #1;
    chk(memSelN && ioSelN && idle && !latchPin, "R1 start in window dropped",
        {memSelN, ioSelN, idle, latchPin}, 4'b1110);

    // directed: 24-bit word access = address + two reads, zero and long latency
    runCycle(1'b1, 1'b0, 1'b1, 17'h1_0ABC, 0, 16'h0, 1'b0);
    runCycle(1'b0, 1'b0, 1'b1, 17'h0_0000, 0, 16'hA5C3, 1'b0);
    runCycle(1'b0, 1'b0, 1'b1, 17'h0_0000, 7, 16'h003C, 1'b0);
    runCycle(1'b0, 1'b1, 1'b0, 17'h1_FFFF, 1, 16'h0, 1'b0);
    // R8: stray start while busy
    runCycle(1'b0, 1'b1, 1'b1, 17'h0_4321, 8, 16'h0, 1'b1);
    runCycle(1'b0, 1'b0, 1'b0, 17'h0_0000, 9, 16'h7E81, 1'b1);
    // R9: abort during the wait phase
    abortRun(1'b0);
    abortRun(1'b1);
    runCycle(1'b0, 1'b0, 1'b0, 17'h0_0000, 2, 16'hC0DE, 1'b0);

    for (int n = 0; n < 40; n++) begin
      bit a, w, m;
      a = 1'($urandom);
      w = 1'($urandom);
      m = 1'($urandom);
      runCycle(a, w, m, 17'($urandom), int'($urandom % 6), 16'($urandom), 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule